// File: doc/BRIEF.md
# Oversampled Short-Frame Command Detector

This block sits behind the envelope demodulator of a contactless card front end. It watches the reader-to-card signal, one sample per clock, with the sample clock running at four times the bit rate. A configuration input selects twice the bit rate instead. The block idles until the input shows a start-of-frame pattern drawn at the selected ratio. It then stores exactly 32 consecutive samples in one word and decodes that word as a whole into a seven-bit short frame plus its closing logic 0.

Only two frame values are accepted: the request command (0x26) and the wake-up command (0x52). When one of them arrives and is closed by a pause-free bit period, the block raises the matching one-clock pulse. At the same time it updates the command type and the value of the final data bit. Downstream timing logic uses that last bit to pick the card's response delay. A coding error, any other frame value or a pause in the closing period abandons the frame. The capture counter and sample word are cleared and the block goes back to hunting for a new start.

Top module: `scd_short_cmd_det`

## Requirements
- R1: While and after reset, req_det_o, wup_det_o, cmd_type_o and last_bit_o are 0 and the block hunts for a start of frame.
- R2: The input is 1 for carrier and 0 for a pause. At 4x (half_rate_i = 0) a start of frame is the sample sequence 1,0,1,1,1. At 2x (half_rate_i = 1) it is 1,0,1. Capture begins with the next sample. The ratio in use is taken when the start is matched, so a frame drawn at the other ratio is never accepted.
- R3: Each bit period holds a single pause sample. At 4x, a logic 1 is 1,1,0,1. A logic 0 that follows a 0 is 0,1,1,1, and a logic 0 that follows a 1 is 1,1,1,1. At 2x these are 1,0 / 0,1 / 1,1. The start of frame counts as a preceding 0, and data is sent LSB first.
- R4: A decoded frame 0x26 gives a one-clock pulse on req_det_o, with cmd_type_o = 0.
- R5: A decoded frame 0x52 gives a one-clock pulse on wup_det_o, with cmd_type_o = 1.
- R6: last_bit_o takes the frame's seventh (final) data bit when a pulse is raised. cmd_type_o and last_bit_o keep their values until the next accepted frame.
- R7: After the closing logic 0, one further bit period of carrier-only samples (4 at 4x, 2 at 2x) is required. The pulse is high for exactly the one clock cycle after the edge that takes the last of those samples.
- R8: A correctly coded frame with any other value gives no pulse and leaves cmd_type_o and last_bit_o unchanged.
- R9: A sample group that is not one of the R3 patterns, a 0 coded as a 1-after-0 pattern, or a logic 1 where the closing logic 0 belongs, gives no pulse.
- R10: A pause anywhere in the closing carrier-only period gives no pulse.
- R11: At 2x, the 32-sample word also spans samples 16 to 31, and all of them must be carrier. A pause there gives no pulse.
- R12: After any abandoned frame, a valid frame that follows after idle carrier is detected normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock, one sample per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_i | input | 1 | Demodulated input: 1 carrier, 0 pause |
| half_rate_i | input | 1 | 0: four samples per bit, 1: two samples per bit |
| req_det_o | output | 1 | One-clock pulse on an accepted request frame |
| wup_det_o | output | 1 | One-clock pulse on an accepted wake-up frame |
| cmd_type_o | output | 1 | Type of the last accepted frame: 0 request, 1 wake-up |
| last_bit_o | output | 1 | Final data bit of the last accepted frame |

## Verification
The bench uses the default parameters: a 32-sample word, ratios of 4 and 2, and codes 0x26 and 0x52. At these values the word holds exactly the data bits and the closing zero at 4x. At 2x it holds those plus eight idle periods, so the trailing-idle rule of R11 is covered along with the tail check. Because the two codes end in different final bits, both last-bit values can be seen at both ratios. Feeding a 2x-drawn frame while 4x is selected brings a false start on the trailing idle within reach, and the bench confirms it is rejected.

// File: rtl/scd_pkg.sv
`timescale 1ns/1ps
package scd_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_CAPT = 2'd1,
    ST_TAIL = 2'd2
  } scd_state_e;

  typedef enum logic [1:0] {
    SYM_Z   = 2'd0,
    SYM_X   = 2'd1,
    SYM_Y   = 2'd2,
    SYM_BAD = 2'd3
  } scd_sym_e;

endpackage

// File: rtl/scd_rst_sync.sv
`timescale 1ns/1ps
module scd_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/scd_sof_det.sv
`timescale 1ns/1ps
module scd_sof_det #(
  parameter int OS_HI = 4,
  parameter int OS_LO = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hunt_i,
  input  logic clr_i,
  input  logic rx_i,
  input  logic half_i,
  output logic sof_o
);

  localparam int HIST_W = OS_HI + 1;
  localparam logic [HIST_W-1:0] PAT_HI = {2'b10, {(OS_HI-1){1'b1}}};
  localparam logic [OS_LO:0]    PAT_LO = {2'b10, {(OS_LO-1){1'b1}}};

  logic [HIST_W-2:0] hist_q;
  logic [HIST_W-2:0] hist_d;
  logic [HIST_W-1:0] window;
  logic              match_hi;
  logic              match_lo;

  // oldest sample at the MSB, current input at the LSB
  assign window   = {hist_q, rx_i};
  assign match_hi = (window == PAT_HI);
  assign match_lo = (window[OS_LO:0] == PAT_LO);
  assign sof_o    = hunt_i & (half_i ? match_lo : match_hi);

  always_comb begin
    hist_d = hist_q;
    if (clr_i) begin
      hist_d = '0;
    end else if (hunt_i) begin
      hist_d = window[HIST_W-2:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

endmodule

// File: rtl/scd_capture.sv
`timescale 1ns/1ps
module scd_capture #(
  parameter int CAP_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             clr_i,
  input  logic             rx_i,
  output logic [CAP_W-1:0] word_o
);

  logic [CAP_W-1:0] word_q;
  logic [CAP_W-1:0] word_d;

  // after CAP_W shifts the first captured sample sits at bit 0
  always_comb begin
    word_d = word_q;
    if (clr_i) begin
      word_d = '0;
    end else if (shift_i) begin
      word_d = {rx_i, word_q[CAP_W-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
    end else begin
      word_q <= word_d;
    end
  end

  assign word_o = word_q;

endmodule

// File: rtl/scd_miller_dec.sv
`timescale 1ns/1ps
module scd_miller_dec
  import scd_pkg::*;
#(
  parameter int                CAP_W  = 32,
  parameter int                OS_HI  = 4,
  parameter int                OS_LO  = 2,
  parameter int                DATA_W = 7,
  parameter logic [DATA_W-1:0] CMD_A  = 7'h26,
  parameter logic [DATA_W-1:0] CMD_B  = 7'h52
) (
  input  logic [CAP_W-1:0] word_i,
  input  logic             half_i,
  output logic             ok_o,
  output logic             is_b_o,
  output logic             last_o
);

  localparam int PER_HI    = CAP_W / OS_HI;
  localparam int PER_LO    = CAP_W / OS_LO;
  localparam int FRAME_PER = DATA_W + 1;

  localparam logic [OS_HI-1:0] HI_Y = '1;
  localparam logic [OS_HI-1:0] HI_X = ~(OS_HI'(1) << (OS_HI / 2));
  localparam logic [OS_HI-1:0] HI_Z = ~OS_HI'(1);
  localparam logic [OS_LO-1:0] LO_Y = '1;
  localparam logic [OS_LO-1:0] LO_X = ~(OS_LO'(1) << (OS_LO / 2));
  localparam logic [OS_LO-1:0] LO_Z = ~OS_LO'(1);

  scd_sym_e sym_hi [PER_HI];
  scd_sym_e sym_lo [PER_LO];

  for (genvar p = 0; p < PER_HI; p++) begin : g_hi
    logic [OS_HI-1:0] grp;
    assign grp = word_i[p*OS_HI +: OS_HI];
    assign sym_hi[p] = (grp == HI_Y) ? SYM_Y :
                       (grp == HI_X) ? SYM_X :
                       (grp == HI_Z) ? SYM_Z : SYM_BAD;
  end

  for (genvar p = 0; p < PER_LO; p++) begin : g_lo
    logic [OS_LO-1:0] grp;
    assign grp = word_i[p*OS_LO +: OS_LO];
    assign sym_lo[p] = (grp == LO_Y) ? SYM_Y :
                       (grp == LO_X) ? SYM_X :
                       (grp == LO_Z) ? SYM_Z : SYM_BAD;
  end

  scd_sym_e              cur_sym;
  logic                  prev_bit;
  logic                  code_ok;
  logic                  trail_ok;
  logic [FRAME_PER-1:0]  bits;
  logic [DATA_W-1:0]     data;

  // walk the periods in arrival order, tracking the previous bit value
  always_comb begin
    cur_sym  = SYM_BAD;
    prev_bit = 1'b0;
    code_ok  = 1'b1;
    bits     = '0;
    for (int p = 0; p < FRAME_PER; p++) begin
      cur_sym = half_i ? sym_lo[p] : sym_hi[p];
      case (cur_sym)
        SYM_X: begin
          bits[p]  = 1'b1;
        end
        SYM_Z: begin
          bits[p]  = 1'b0;
          if (prev_bit) code_ok = 1'b0;
        end
        SYM_Y: begin
          bits[p]  = 1'b0;
          if (!prev_bit) code_ok = 1'b0;
        end
        default: begin
          code_ok  = 1'b0;
        end
      endcase
      prev_bit = bits[p];
    end
  end

  // periods after the closing zero must carry no pause
  always_comb begin
    trail_ok = 1'b1;
    for (int p = FRAME_PER; p < PER_LO; p++) begin
      if (half_i && (sym_lo[p] != SYM_Y)) trail_ok = 1'b0;
    end
    for (int p = FRAME_PER; p < PER_HI; p++) begin
      if (!half_i && (sym_hi[p] != SYM_Y)) trail_ok = 1'b0;
    end
  end

  assign data   = bits[DATA_W-1:0];
  assign is_b_o = (data == CMD_B);
  assign last_o = bits[DATA_W-1];
  assign ok_o   = code_ok & trail_ok & ~bits[DATA_W] &
                  ((data == CMD_A) | (data == CMD_B));

endmodule

// File: rtl/scd_short_cmd_det.sv
`timescale 1ns/1ps
module scd_short_cmd_det
  import scd_pkg::*;
#(
  parameter int                CAP_W  = 32,
  parameter int                OS_HI  = 4,
  parameter int                OS_LO  = 2,
  parameter int                DATA_W = 7,
  parameter logic [DATA_W-1:0] CMD_A  = 7'h26,
  parameter logic [DATA_W-1:0] CMD_B  = 7'h52
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic half_rate_i,
  output logic req_det_o,
  output logic wup_det_o,
  output logic cmd_type_o,
  output logic last_bit_o
);

  localparam int               CNT_W    = $clog2(CAP_W);
  localparam logic [CNT_W-1:0] CAP_LAST = CNT_W'(CAP_W - 1);
  localparam logic [CNT_W-1:0] TAIL_HI  = CNT_W'(OS_HI - 1);
  localparam logic [CNT_W-1:0] TAIL_LO  = CNT_W'(OS_LO - 1);

  logic             rst_n;
  scd_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rate_q, rate_d;
  logic             req_q, req_d;
  logic             wup_q, wup_d;
  logic             type_q, type_d;
  logic             last_q, last_d;

  logic             hunt;
  logic             shift;
  logic             restart;
  logic             fire;
  logic             sof_hit;
  logic [CAP_W-1:0] word;
  logic             dec_ok;
  logic             dec_is_b;
  logic             dec_last;
  logic [CNT_W-1:0] tail_last;

  scd_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  scd_sof_det #(
    .OS_HI (OS_HI),
    .OS_LO (OS_LO)
  ) u_sof (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .hunt_i (hunt),
    .clr_i  (restart),
    .rx_i   (rx_i),
    .half_i (half_rate_i),
    .sof_o  (sof_hit)
  );

  scd_capture #(
    .CAP_W (CAP_W)
  ) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .shift_i (shift),
    .clr_i   (restart),
    .rx_i    (rx_i),
    .word_o  (word)
  );

  scd_miller_dec #(
    .CAP_W  (CAP_W),
    .OS_HI  (OS_HI),
    .OS_LO  (OS_LO),
    .DATA_W (DATA_W),
    .CMD_A  (CMD_A),
    .CMD_B  (CMD_B)
  ) u_dec (
    .word_i (word),
    .half_i (rate_q),
    .ok_o   (dec_ok),
    .is_b_o (dec_is_b),
    .last_o (dec_last)
  );

  assign hunt      = (state_q == ST_HUNT);
  assign tail_last = rate_q ? TAIL_LO : TAIL_HI;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rate_d  = rate_q;
    shift   = 1'b0;
    restart = 1'b0;
    fire    = 1'b0;
    case (state_q)
      ST_HUNT: begin
        if (sof_hit) begin
          state_d = ST_CAPT;
          cnt_d   = '0;
          rate_d  = half_rate_i;
        end
      end
      ST_CAPT: begin
        shift = 1'b1;
        if (cnt_q == CAP_LAST) begin
          state_d = ST_TAIL;
          cnt_d   = '0;
        end else begin
          cnt_d   = cnt_q + CNT_W'(1);
        end
      end
      ST_TAIL: begin
        if (!dec_ok || !rx_i) begin
          restart = 1'b1;
        end else if (cnt_q == tail_last) begin
          fire    = 1'b1;
          restart = 1'b1;
        end else begin
          cnt_d   = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        restart = 1'b1;
      end
    endcase
    if (restart) begin
      state_d = ST_HUNT;
      cnt_d   = '0;
    end
  end

  always_comb begin
    req_d  = fire & ~dec_is_b;
    wup_d  = fire & dec_is_b;
    type_d = fire ? dec_is_b : type_q;
    last_d = fire ? dec_last : last_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      rate_q  <= 1'b0;
      req_q   <= 1'b0;
      wup_q   <= 1'b0;
      type_q  <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rate_q  <= rate_d;
      req_q   <= req_d;
      wup_q   <= wup_d;
      type_q  <= type_d;
      last_q  <= last_d;
    end
  end

  assign req_det_o  = req_q;
  assign wup_det_o  = wup_q;
  assign cmd_type_o = type_q;
  assign last_bit_o = last_q;

endmodule

// File: rtl/scd_short_cmd_det_chk.sv
`timescale 1ns/1ps
module scd_short_cmd_det_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_i,
  input logic req_det_o,
  input logic wup_det_o,
  input logic cmd_type_o,
  input logic last_bit_o
);

  AST_REQ_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_det_o |-> (!cmd_type_o && !last_bit_o)); // R4

  AST_WUP_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wup_det_o |-> (cmd_type_o && last_bit_o)); // R5

  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_det_o || wup_det_o) |-> ($stable(cmd_type_o) && $stable(last_bit_o))); // R6

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_det_o || wup_det_o) |=> !(req_det_o || wup_det_o)); // R7

  AST_TAIL_CARRIER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_det_o || wup_det_o) |-> $past(rx_i)); // R10

endmodule

bind scd_short_cmd_det scd_short_cmd_det_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_i       (rx_i),
  .req_det_o  (req_det_o),
  .wup_det_o  (wup_det_o),
  .cmd_type_o (cmd_type_o),
  .last_bit_o (last_bit_o)
);

// File: tb/scd_short_cmd_det_tb_top.sv
`timescale 1ns/1ps
module scd_short_cmd_det_tb_top;

  logic clk;
  logic rst_n;
  logic rx;
  logic half_rate;
  logic req_det;
  logic wup_det;
  logic cmd_type;
  logic last_bit;

  int n_checks;
  int n_fails;
  int n_pulses;
  bit done;

  scd_short_cmd_det dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rx_i        (rx),
    .half_rate_i (half_rate),
    .req_det_o   (req_det),
    .wup_det_o   (wup_det),
    .cmd_type_o  (cmd_type),
    .last_bit_o  (last_bit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // pulse counter sampled away from the active edge
  always @(negedge clk) begin
    if (req_det || wup_det) n_pulses++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v);
    @(negedge clk);
    rx = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b1);
  endtask

  // s: 0 = pause first, 1 = pause second half, 2 = no pause, 3 = illegal
  task automatic emit_sym(input int s, input bit h);
    logic [3:0] pat;
    if (h) begin
      case (s)
        0: pat = 4'b0100;
        1: pat = 4'b1000;
        2: pat = 4'b1100;
        default: pat = 4'b0000;
      endcase
      for (int i = 3; i >= 2; i--) drive(pat[i]);
    end else begin
      case (s)
        0: pat = 4'b0111;
        1: pat = 4'b1101;
        2: pat = 4'b1111;
        default: pat = 4'b0011;
      endcase
      for (int i = 3; i >= 0; i--) drive(pat[i]);
    end
  endtask

  // bits[6:0] data LSB first, bits[7] the closing bit (0 when legal)
  task automatic send_frame(input logic [7:0] bits, input bit drv_half, input bit cfg_half,
                            input int bad_per, input int trail_pause, input int tail_pause);
    logic prev;
    int   s;
    half_rate = cfg_half;
    idle(8);
    emit_sym(0, drv_half);
    prev = 1'b0;
    for (int p = 0; p < 8; p++) begin
      if (bits[p]) s = 1;
      else s = prev ? 2 : 0;
      if (p == bad_per) s = 3;
      emit_sym(s, drv_half);
      prev = bits[p];
    end
    if (drv_half) begin
      for (int i = 0; i < 16; i++) drive((i == trail_pause) ? 1'b0 : 1'b1);
    end
    for (int i = 0; i < (drv_half ? 2 : 4); i++) drive((i == tail_pause) ? 1'b0 : 1'b1);
  endtask

  task automatic expect_hit(input logic [6:0] code, input bit h, input bit is_wup, input string tag);
    send_frame({1'b0, code}, h, h, -1, -1, -1);
    @(negedge clk);
    rx = 1'b1;
    chk(req_det == !is_wup, {tag, " req pulse"}, int'(req_det), int'(!is_wup));
    chk(wup_det == is_wup, {tag, " wup pulse"}, int'(wup_det), int'(is_wup));
    chk(cmd_type == is_wup, {tag, " cmd type"}, int'(cmd_type), int'(is_wup));
    chk(last_bit == code[6], {"R6 ", tag, " last bit"}, int'(last_bit), int'(code[6]));
    @(negedge clk);
    chk(!(req_det || wup_det), {"R7 ", tag, " pulse width"}, int'(req_det || wup_det), 0);
    idle(50);
  endtask

  task automatic expect_miss(input logic [7:0] bits, input bit drv_half, input bit cfg_half,
                             input int bad_per, input int trail_pause, input int tail_pause,
                             input string tag);
    int   p0;
    logic t0;
    logic l0;
    p0 = n_pulses;
    t0 = cmd_type;
    l0 = last_bit;
    send_frame(bits, drv_half, cfg_half, bad_per, trail_pause, tail_pause);
    idle(50);
    chk(n_pulses == p0, {tag, " no pulse"}, n_pulses - p0, 0);
    chk(cmd_type == t0 && last_bit == l0, {tag, " result unchanged"},
        int'({cmd_type, last_bit}), int'({t0, l0}));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    rx = 1'b1;
    half_rate = 1'b0;
    repeat (5) @(negedge clk);
    chk({req_det, wup_det, cmd_type, last_bit} == 4'b0, "R1 in reset",
        int'({req_det, wup_det, cmd_type, last_bit}), 0);
    rst_n = 1'b1;
    idle(6);
    chk({req_det, wup_det, cmd_type, last_bit} == 4'b0, "R1 after reset",
        int'({req_det, wup_det, cmd_type, last_bit}), 0);
  endtask

  task automatic t_fast_req;   expect_hit(7'h26, 1'b0, 1'b0, "R4 R3 R7 fast request"); endtask
  task automatic t_fast_wup;   expect_hit(7'h52, 1'b0, 1'b1, "R5 R3 R7 fast wakeup"); endtask

  task automatic t_hold;
    idle(40);
    chk(cmd_type == 1'b1 && last_bit == 1'b1, "R6 hold after wakeup",
        int'({cmd_type, last_bit}), 3);
  endtask

  task automatic t_slow_req;   expect_hit(7'h26, 1'b1, 1'b0, "R2 R3 slow request"); endtask
  task automatic t_slow_wup;   expect_hit(7'h52, 1'b1, 1'b1, "R2 R5 slow wakeup"); endtask

  task automatic t_ratio_mismatch;
    expect_miss({1'b0, 7'h26}, 1'b1, 1'b0, -1, -1, -1, "R2 ratio mismatch");
  endtask

  task automatic t_other_value;
    expect_miss({1'b0, 7'h35}, 1'b0, 1'b0, -1, -1, -1, "R8 other value fast");
    expect_miss({1'b0, 7'h26 ^ 7'h01}, 1'b1, 1'b1, -1, -1, -1, "R8 other value slow");
  endtask

  task automatic t_violation;
    expect_miss({1'b0, 7'h26}, 1'b0, 1'b0, 3, -1, -1, "R9 illegal group");
    expect_miss({1'b1, 7'h52}, 1'b0, 1'b0, -1, -1, -1, "R9 closing bit one");
  endtask

  task automatic t_tail_pause;
    expect_miss({1'b0, 7'h26}, 1'b0, 1'b0, -1, -1, 2, "R10 tail pause fast");
    expect_miss({1'b0, 7'h52}, 1'b1, 1'b1, -1, -1, 1, "R10 tail pause slow");
  endtask

  task automatic t_trailer_pause;
    expect_miss({1'b0, 7'h26}, 1'b1, 1'b1, -1, 5, -1, "R11 trailer pause");
  endtask

  task automatic t_rearm;
    expect_miss({1'b0, 7'h26}, 1'b0, 1'b0, 0, -1, -1, "R12 abort first");
    expect_hit(7'h52, 1'b0, 1'b1, "R12 rearm wakeup");
    expect_miss({1'b0, 7'h52}, 1'b1, 1'b1, -1, -1, 0, "R12 abort slow");
    expect_hit(7'h26, 1'b1, 1'b0, "R12 rearm request");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    n_checks = 0;
    n_fails  = 0;
    n_pulses = 0;
    done     = 1'b0;
    t_reset();
    t_fast_req();
    t_fast_wup();
    t_hold();
    t_slow_req();
    t_slow_wup();
    t_ratio_mismatch();
    t_other_value();
    t_violation();
    t_tail_pause();
    t_trailer_pause();
    t_rearm();
    finish_run();
  end

endmodule